// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is one DMA channel that moves sample data between system memory and an internal sample port by following a table of buffer descriptors. Each descriptor takes two 32-bit words in memory. The first word gives the start address of a buffer. The second word gives the buffer's length in bytes, plus two marker bits. Software places the table in memory and loads its address into the channel. It then raises the run enable and pulses start. The channel fetches each descriptor, streams its buffer one word at a time, and steps to the next entry. It continues until it reaches the entry that marks the end of the list.

The channel can either stop at the end of the list or wrap back to the first entry and keep going. A status flag records that the end of the list has been reached. Two independently enabled interrupt pulses report the completion of the last entry and the completion of any entry whose flag marker is set. Dropping the run enable halts the channel cleanly, once the memory access already in progress has been answered.

The memory side is a single-word request/acknowledge port. One request is outstanding at a time. Read data arrives together with the acknowledge. The sample side has no handshake. Read data is presented on a one-cycle valid strobe, and write data is taken from the input bus while the write request is answered.

Top module: `sgd_dma_channel`

## Requirements
- R1: After start, the channel reads descriptor word 0 at the current pointer, then word 1 at pointer+4, then performs that entry's data accesses, then continues with the next descriptor at pointer+8.
- R2: Word 0 is the buffer start address. Bits 23:0 of word 1 are the byte count, bit 31 is the end-of-list marker and bit 30 is the flag marker. Bits 29:24 have no effect.
- R3: An entry with count N makes ceil(N/4) data accesses at consecutive word addresses from its start address. With direction 0 each is a read, and the read word appears on `smp_out_data` with `smp_out_valid` high for one cycle, in the cycle after the acknowledge. With direction 1 each is a write of `smp_in_data`.
- R4: An entry with a byte count of zero makes no data access. The channel goes straight on to the next descriptor.
- R5: When an end-of-list entry completes with looping off, the channel returns to idle: `busy` is low and no request is made. `stat_eol` is then set, and an accepted start clears it.
- R6: With looping on and run still high, completion of an end-of-list entry makes the next descriptor fetch start at the table base again.
- R7: `irq_eol` pulses for one cycle when an end-of-list entry completes, and only if its enable is high. `irq_flag` does the same for an entry with the flag marker and its own enable. The two enables act independently.
- R8: With run low, once the pending memory access is acknowledged the channel makes no further request and returns to idle.
- R9: Bits 1:0 of the table base are ignored, so the first fetch is word-aligned.
- R10: Once raised, a request keeps its address and direction unchanged until it is acknowledged.
- R11: After reset the channel is idle, with no request, no sample strobe, no interrupt and `stat_eol` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_run | input | 1 | Run enable; low stops after the pending access |
| cfg_start | input | 1 | Start pulse, taken only while idle with run high |
| cfg_loop | input | 1 | Wrap to the table base after the end-of-list entry |
| cfg_dir | input | 1 | 0 memory to port, 1 port to memory (latched at start) |
| cfg_ie_eol | input | 1 | Enable for the end-of-list interrupt |
| cfg_ie_flag | input | 1 | Enable for the flag interrupt |
| cfg_table_base | input | ADDR_W | Byte address of the descriptor table |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request answered this cycle |
| mem_rdata | input | 32 | Read data, valid with the acknowledge |
| smp_in_data | input | 32 | Sample word to be written |
| smp_out_valid | output | 1 | Read sample strobe |
| smp_out_data | output | 32 | Read sample word |
| busy | output | 1 | Channel is not idle |
| stat_eol | output | 1 | End of list has been reached |
| irq_eol | output | 1 | End-of-list interrupt pulse |
| irq_flag | output | 1 | Flag interrupt pulse |
| cur_ptr | output | ADDR_W | Address of the current descriptor |
| cur_addr | output | ADDR_W | Next buffer address to access |
| cur_count | output | CNT_W | Bytes still to move in the current buffer |

## Verification
The channel is run on directed tables and on seeded random ones, using the tables below.
- A table with byte counts 1, 5, 0 and 8 exposes errors in the rounding of the beat count and in the skipping of empty entries.
- Random filler in bits 29:24 of the count word and a misaligned table base show whether the decoding ignores those bits.
- Tables run in each direction, with each interrupt enable set alone, separate the read path from the write path and the two interrupt paths from each other.
- A looped table and a mid-buffer stop check that the channel wraps at end of list and that it drains after run drops.

The random memory latency tests whether requests are held until acknowledged.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_FETCH_ADR = 3'd1,
      ST_FETCH_CNT = 3'd2,
      ST_MOVE      = 3'd3,
      ST_NEXT      = 3'd4
   } sgd_state_e;

   localparam int unsigned WORD_BYTES  = 4;
   localparam int unsigned DESC_STRIDE = 8;
   localparam int unsigned BUS_W       = 32;
   localparam int unsigned EOL_POS     = 31;
   localparam int unsigned FLAG_POS    = 30;
   localparam int unsigned CNT_FIELD_W = 24;
endpackage

// File: rtl/sgd_field_split.sv
module sgd_field_split
   import sgd_pkg::*;
#(
   parameter int unsigned CNT_W = 24
) (
   input  logic [BUS_W-1:0] word_i,
   output logic [CNT_W-1:0] count_o,
   output logic             eol_o,
   output logic             flag_o
);
   if (CNT_W < 3 || CNT_W > CNT_FIELD_W) begin : g_bad_width
      $error("sgd_field_split: CNT_W out of range");
   end

   // Marker bits sit at fixed positions in the count word.
   assign eol_o  = word_i[EOL_POS];
   assign flag_o = word_i[FLAG_POS];

   if (CNT_W == CNT_FIELD_W) begin : g_full
      assign count_o = word_i[CNT_FIELD_W-1:0];
   end else begin : g_narrow
      // Upper part of the count field is dropped for a narrow channel.
      assign count_o = word_i[CNT_W-1:0];
   end
endmodule

// File: rtl/sgd_remain_step.sv
module sgd_remain_step
   import sgd_pkg::*;
#(
   parameter int unsigned CNT_W = 24
) (
   input  logic [CNT_W-1:0] remain_i,
   output logic [CNT_W-1:0] remain_next_o,
   output logic             last_beat_o
);
   localparam logic [CNT_W-1:0] BEAT = CNT_W'(WORD_BYTES);

   // A beat moves one word; a tail of fewer bytes still costs a full beat.
   assign last_beat_o   = (remain_i <= BEAT);
   assign remain_next_o = last_beat_o ? '0 : (remain_i - BEAT);
endmodule

// File: rtl/sgd_event_reg.sv
module sgd_event_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_stat,
   input  logic fire,
   input  logic is_eol,
   input  logic is_flag,
   input  logic ie_eol,
   input  logic ie_flag,
   output logic stat_eol,
   output logic irq_eol,
   output logic irq_flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_eol <= 1'b0;
         irq_eol  <= 1'b0;
         irq_flag <= 1'b0;
      end else begin
         irq_eol  <= fire & is_eol & ie_eol;
         irq_flag <= fire & is_flag & ie_flag;
         if (clear_stat) begin
            stat_eol <= 1'b0;
         end else if (fire && is_eol) begin
            stat_eol <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/sgd_dma_channel.sv
module sgd_dma_channel
   import sgd_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned CNT_W  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_run,
   input  logic              cfg_start,
   input  logic              cfg_loop,
   input  logic              cfg_dir,
   input  logic              cfg_ie_eol,
   input  logic              cfg_ie_flag,
   input  logic [ADDR_W-1:0] cfg_table_base,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   input  logic [31:0]       smp_in_data,
   output logic              smp_out_valid,
   output logic [31:0]       smp_out_data,
   output logic              busy,
   output logic              stat_eol,
   output logic              irq_eol,
   output logic              irq_flag,
   output logic [ADDR_W-1:0] cur_ptr,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [CNT_W-1:0]  cur_count
);
   localparam int unsigned ALIGN_W = $clog2(WORD_BYTES);
   localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(WORD_BYTES);
   localparam logic [ADDR_W-1:0] STEP_DESC = ADDR_W'(DESC_STRIDE);

   if (ADDR_W < 8 || ADDR_W > BUS_W) begin : g_bad_addr
      $error("sgd_dma_channel: ADDR_W must lie in 8..32");
   end

   sgd_state_e        state_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  remain_q;
   logic              eol_q;
   logic              flag_q;
   logic              dir_q;

   logic [ADDR_W-1:0] base_aligned;
   logic              start_ok;
   logic [CNT_W-1:0]  f_count;
   logic              f_eol;
   logic              f_flag;
   logic [CNT_W-1:0]  remain_next;
   logic              last_beat;
   logic              take;

   assign base_aligned = {cfg_table_base[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
   assign start_ok     = (state_q == ST_IDLE) && cfg_start && cfg_run;
   assign take         = mem_req && mem_ack;

   sgd_field_split #(.CNT_W(CNT_W)) u_split (
      .word_i  (mem_rdata),
      .count_o (f_count),
      .eol_o   (f_eol),
      .flag_o  (f_flag)
   );

   sgd_remain_step #(.CNT_W(CNT_W)) u_step (
      .remain_i      (remain_q),
      .remain_next_o (remain_next),
      .last_beat_o   (last_beat)
   );

   sgd_event_reg u_evt (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_stat (start_ok),
      .fire       (state_q == ST_NEXT),
      .is_eol     (eol_q),
      .is_flag    (flag_q),
      .ie_eol     (cfg_ie_eol),
      .ie_flag    (cfg_ie_flag),
      .stat_eol   (stat_eol),
      .irq_eol    (irq_eol),
      .irq_flag   (irq_flag)
   );

   // Memory request decode from the current state.
   always_comb begin
      mem_req  = 1'b0;
      mem_we   = 1'b0;
      mem_addr = ptr_q;
      unique case (state_q)
         ST_FETCH_ADR: begin
            mem_req  = 1'b1;
            mem_addr = ptr_q;
         end
         ST_FETCH_CNT: begin
            mem_req  = 1'b1;
            mem_addr = ptr_q + STEP_WORD;
         end
         ST_MOVE: begin
            mem_req  = 1'b1;
            mem_we   = dir_q;
            mem_addr = addr_q;
         end
         default: begin
            mem_req  = 1'b0;
         end
      endcase
   end

   assign mem_wdata = smp_in_data;

   // Descriptor walk.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         ptr_q    <= '0;
         addr_q   <= '0;
         remain_q <= '0;
         eol_q    <= 1'b0;
         flag_q   <= 1'b0;
         dir_q    <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_ok) begin
                  ptr_q   <= base_aligned;
                  dir_q   <= cfg_dir;
                  state_q <= ST_FETCH_ADR;
               end
            end
            ST_FETCH_ADR: begin
               if (take) begin
                  addr_q  <= mem_rdata[ADDR_W-1:0];
                  state_q <= cfg_run ? ST_FETCH_CNT : ST_IDLE;
               end
            end
            ST_FETCH_CNT: begin
               if (take) begin
                  remain_q <= f_count;
                  eol_q    <= f_eol;
                  flag_q   <= f_flag;
                  if (!cfg_run) begin
                     state_q <= ST_IDLE;
                  end else if (f_count == '0) begin
                     state_q <= ST_NEXT;
                  end else begin
                     state_q <= ST_MOVE;
                  end
               end
            end
            ST_MOVE: begin
               if (take) begin
                  addr_q   <= addr_q + STEP_WORD;
                  remain_q <= remain_next;
                  if (!cfg_run) begin
                     state_q <= ST_IDLE;
                  end else if (last_beat) begin
                     state_q <= ST_NEXT;
                  end
               end
            end
            ST_NEXT: begin
               if (eol_q) begin
                  if (cfg_loop && cfg_run) begin
                     ptr_q   <= base_aligned;
                     state_q <= ST_FETCH_ADR;
                  end else begin
                     state_q <= ST_IDLE;
                  end
               end else begin
                  ptr_q   <= ptr_q + STEP_DESC;
                  state_q <= cfg_run ? ST_FETCH_ADR : ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // Read samples leave one cycle after their acknowledge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_out_valid <= 1'b0;
         smp_out_data  <= '0;
      end else begin
         smp_out_valid <= (state_q == ST_MOVE) && take && !dir_q;
         if ((state_q == ST_MOVE) && take && !dir_q) begin
            smp_out_data <= mem_rdata;
         end
      end
   end

   assign busy      = (state_q != ST_IDLE);
   assign cur_ptr   = ptr_q;
   assign cur_addr  = addr_q;
   assign cur_count = remain_q;
endmodule

// File: rtl/sgd_dma_channel_chk.sv
module sgd_dma_channel_chk #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_run,
   input logic [ADDR_W-1:0] cfg_table_base,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ack,
   input logic              smp_out_valid,
   input logic              busy,
   input logic              stat_eol,
   input logic              irq_eol,
   input logic              irq_flag
);
   localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);

   assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);

   assert_eol_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_eol |-> stat_eol);

   assert_flag_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_flag |=> !irq_flag);

   assert_first_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !$past(busy) |-> mem_addr == ($past(cfg_table_base) & ALIGN_MASK));

   assert_sample_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      smp_out_valid |-> $past(mem_req && mem_ack && !mem_we));

   assert_stop_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ack && !cfg_run |=> !mem_req);
endmodule

bind sgd_dma_channel sgd_dma_channel_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cfg_run        (cfg_run),
   .cfg_table_base (cfg_table_base),
   .mem_req        (mem_req),
   .mem_we         (mem_we),
   .mem_addr       (mem_addr),
   .mem_ack        (mem_ack),
   .smp_out_valid  (smp_out_valid),
   .busy           (busy),
   .stat_eol       (stat_eol),
   .irq_eol        (irq_eol),
   .irq_flag       (irq_flag)
);

// File: tb/tb_sgd_dma_channel.sv
module tb_sgd_dma_channel;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 32;
   localparam int CNT_W  = 24;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              cfg_run, cfg_start, cfg_loop, cfg_dir, cfg_ie_eol, cfg_ie_flag;
   logic [ADDR_W-1:0] cfg_table_base;
   logic              mem_req, mem_we, mem_ack;
   logic [ADDR_W-1:0] mem_addr;
   logic [31:0]       mem_wdata, mem_rdata, smp_in_data, smp_out_data;
   logic              smp_out_valid, busy, stat_eol, irq_eol, irq_flag;
   logic [ADDR_W-1:0] cur_ptr, cur_addr;
   logic [CNT_W-1:0]  cur_count;

   always #(CLK_PERIOD/2) clk = ~clk;

   sgd_dma_channel #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_run(cfg_run), .cfg_start(cfg_start),
      .cfg_loop(cfg_loop), .cfg_dir(cfg_dir), .cfg_ie_eol(cfg_ie_eol),
      .cfg_ie_flag(cfg_ie_flag), .cfg_table_base(cfg_table_base),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .smp_in_data(smp_in_data), .smp_out_valid(smp_out_valid),
      .smp_out_data(smp_out_data), .busy(busy), .stat_eol(stat_eol),
      .irq_eol(irq_eol), .irq_flag(irq_flag), .cur_ptr(cur_ptr),
      .cur_addr(cur_addr), .cur_count(cur_count)
   );

   logic [31:0] mem [0:1023];
   logic [32:0] act_trace[$];
   logic [32:0] exp_trace[$];
   logic [31:0] act_smp[$];
   logic [31:0] exp_smp[$];
   int n_checks = 0;
   int n_fails  = 0;
   int n_irq_eol = 0;
   int n_irq_flag = 0;
   int exp_flags = 0;
   int wr_bad = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Memory model with random latency; records every answered access.
   initial begin : mem_model
      int wait_ctr;
      bit last_wr;
      mem_ack = 1'b0;
      mem_rdata = '0;
      smp_in_data = 32'h1357_2468;
      wait_ctr = 0;
      last_wr = 1'b0;
      forever begin
         @(negedge clk);
         mem_ack = 1'b0;
         if (last_wr) smp_in_data = $urandom;
         last_wr = 1'b0;
         if (rst_n && mem_req) begin
            if (wait_ctr == 0) begin
               act_trace.push_back({mem_we, mem_addr});
               if (mem_we) begin
                  if (mem_wdata !== smp_in_data) wr_bad++;
                  mem[mem_addr[11:2]] = mem_wdata;
                  last_wr = 1'b1;
               end else begin
                  mem_rdata = mem[mem_addr[11:2]];
               end
               mem_ack = 1'b1;
               wait_ctr = $urandom % 3;
            end else begin
               wait_ctr--;
            end
         end
      end
   end

   initial begin : out_monitor
      forever begin
         @(negedge clk);
         if (smp_out_valid) act_smp.push_back(smp_out_data);
         if (irq_eol) n_irq_eol++;
         if (irq_flag) n_irq_flag++;
      end
   end

   // Expected access trace from the requirements (R1..R4, R6, R9).
   task automatic build_expect(input logic [31:0] base, input int passes, input bit dir);
      exp_trace.delete();
      exp_smp.delete();
      exp_flags = 0;
      for (int p = 0; p < passes; p++) begin
         logic [31:0] ptr;
         ptr = base & ~32'h3;
         for (int d = 0; d < 64; d++) begin
            logic [31:0] w0, w1;
            int beats;
            w0 = mem[ptr[11:2]];
            w1 = mem[ptr[11:2] + 10'd1];
            exp_trace.push_back({1'b0, ptr});
            exp_trace.push_back({1'b0, ptr + 32'd4});
            beats = (int'(w1[23:0]) + 3) / 4;
            for (int k = 0; k < beats; k++) begin
               logic [31:0] a;
               a = w0 + 32'(4 * k);
               exp_trace.push_back({dir, a});
               if (!dir) exp_smp.push_back(mem[a[11:2]]);
            end
            if (w1[30]) exp_flags++;
            if (w1[31]) break;
            ptr = ptr + 32'd8;
         end
      end
   endtask

   task automatic put_desc(input logic [31:0] at, input logic [31:0] addr,
                           input int cnt, input bit eol, input bit flg, input logic [5:0] junk);
      mem[at[11:2]]         = addr;
      mem[at[11:2] + 10'd1] = {eol, flg, junk, 24'(cnt)};
   endtask

   task automatic fill_data();
      for (int i = 256; i < 1024; i++) mem[i] = $urandom;
   endtask

   task automatic random_table(input logic [31:0] base, input int n);
      for (int d = 0; d < n; d++) begin
         int cnt;
         cnt = (($urandom % 4) == 0) ? 0 : int'($urandom % 41);
         put_desc(base + 32'(8 * d), 32'h400 + 32'(($urandom % 512) * 4), cnt,
                  d == n - 1, 1'($urandom), 6'($urandom));
      end
   endtask

   task automatic wait_idle(input int limit);
      for (int i = 0; i < limit; i++) begin
         @(negedge clk);
         if (!busy) break;
      end
   endtask

   task automatic launch(input logic [31:0] base, input bit dir, input bit loop,
                         input bit ie_e, input bit ie_f, input string req);
      act_trace.delete();
      act_smp.delete();
      n_irq_eol = 0;
      n_irq_flag = 0;
      wr_bad = 0;
      @(negedge clk);
      cfg_table_base = base;
      cfg_dir = dir;
      cfg_loop = loop;
      cfg_ie_eol = ie_e;
      cfg_ie_flag = ie_f;
      cfg_run = 1'b1;
      cfg_start = 1'b1;
      @(negedge clk);
      cfg_start = 1'b0;
      chk(stat_eol == 1'b0, "R5", {req, " status cleared by start"}, stat_eol, 0);
   endtask

   task automatic compare_run(input string req, input bit ie_e, input bit ie_f, input int slack);
      bit tr_ok;
      bit sm_ok;
      int first_bad;
      tr_ok = (act_trace.size() >= exp_trace.size()) &&
              (act_trace.size() <= exp_trace.size() + slack);
      first_bad = -1;
      for (int i = 0; i < exp_trace.size() && i < act_trace.size(); i++) begin
         if (act_trace[i] !== exp_trace[i]) begin
            tr_ok = 1'b0;
            if (first_bad < 0) first_bad = i;
         end
      end
      if (first_bad >= 0)
         chk(1'b0, req, $sformatf("access %0d", first_bad),
             longint'(act_trace[first_bad]), longint'(exp_trace[first_bad]));
      else
         chk(tr_ok, req, "access count", act_trace.size(), exp_trace.size());
      sm_ok = (act_smp.size() >= exp_smp.size());
      for (int i = 0; i < exp_smp.size() && i < act_smp.size(); i++)
         if (act_smp[i] !== exp_smp[i]) sm_ok = 1'b0;
      if (slack == 0) sm_ok = sm_ok && (act_smp.size() == exp_smp.size());
      chk(sm_ok, "R3", {req, " sample stream"}, act_smp.size(), exp_smp.size());
      chk(wr_bad == 0, "R3", {req, " write data"}, wr_bad, 0);
      chk(n_irq_flag == (ie_f ? exp_flags : 0), "R7", {req, " flag irqs"}, n_irq_flag,
          ie_f ? exp_flags : 0);
   endtask

   task automatic one_shot(input logic [31:0] base, input bit dir, input bit ie_e,
                           input bit ie_f, input string req);
      build_expect(base, 1, dir);
      launch(base, dir, 1'b0, ie_e, ie_f, req);
      wait_idle(20000);
      compare_run(req, ie_e, ie_f, 0);
      chk(n_irq_eol == (ie_e ? 1 : 0), "R7", {req, " eol irqs"}, n_irq_eol, ie_e ? 1 : 0);
      chk(busy == 1'b0 && stat_eol == 1'b1, "R5", {req, " idle with status"},
          {busy, stat_eol}, 2'b01);
   endtask

   initial begin : main
      void'($urandom(32'd4711));
      rst_n = 1'b0;
      cfg_run = 1'b0; cfg_start = 1'b0; cfg_loop = 1'b0; cfg_dir = 1'b0;
      cfg_ie_eol = 1'b0; cfg_ie_flag = 1'b0; cfg_table_base = '0;
      for (int i = 0; i < 1024; i++) mem[i] = '0;
      fill_data();
      repeat (3) @(negedge clk);
      chk({busy, mem_req, smp_out_valid, irq_eol, irq_flag, stat_eol} == 6'b0, "R11",
          "reset outputs", {busy, mem_req, smp_out_valid, irq_eol, irq_flag, stat_eol}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R7: single flagged end-of-list entry.
      put_desc(32'h40, 32'h600, 4, 1'b1, 1'b1, 6'h00);
      one_shot(32'h40, 1'b0, 1'b1, 1'b1, "R1 single");

      // R3 R4 R2: rounding, empty entry, filler bits.
      put_desc(32'h00, 32'h800, 1, 1'b0, 1'b0, 6'h3F);
      put_desc(32'h08, 32'h900, 5, 1'b0, 1'b1, 6'h15);
      put_desc(32'h10, 32'hA00, 0, 1'b0, 1'b1, 6'h2A);
      put_desc(32'h18, 32'hB00, 8, 1'b1, 1'b0, 6'h3F);
      one_shot(32'h00, 1'b0, 1'b1, 1'b1, "R4 R2 mixed counts");
      chk(act_trace.size() == 2*4 + 1 + 2 + 0 + 2, "R4", "empty entry skipped",
          act_trace.size(), 13);

      // R3: write direction.
      one_shot(32'h00, 1'b1, 1'b1, 1'b0, "R3 write");

      // R7: enables independent.
      one_shot(32'h00, 1'b0, 1'b0, 1'b1, "R7 flag only");

      // R9: misaligned base.
      one_shot(32'h03, 1'b0, 1'b1, 1'b1, "R9 low bits");

      // R6: looping, stop after two passes.
      build_expect(32'h00, 2, 1'b0);
      launch(32'h00, 1'b0, 1'b1, 1'b1, 1'b1, "R6 loop");
      for (int i = 0; i < 20000 && n_irq_eol < 2; i++) @(negedge clk);
      cfg_run = 1'b0;
      wait_idle(200);
      compare_run("R6", 1'b1, 1'b1, 1);
      chk(busy == 1'b0, "R8", "loop halts on run low", busy, 0);

      // R8: stop during a long buffer.
      put_desc(32'h80, 32'h800, 200, 1'b1, 1'b0, 6'h00);
      build_expect(32'h80, 1, 1'b0);
      launch(32'h80, 1'b0, 1'b0, 1'b1, 1'b1, "R8 stop");
      repeat (25) @(negedge clk);
      cfg_run = 1'b0;
      begin
         int at_stop;
         at_stop = act_trace.size();
         wait_idle(200);
         repeat (5) @(negedge clk);
         chk(act_trace.size() <= at_stop + 1 && act_trace.size() < exp_trace.size(), "R8",
             "accesses after run low", act_trace.size() - at_stop, 1);
         chk(busy == 1'b0 && mem_req == 1'b0, "R8", "idle after stop", {busy, mem_req}, 0);
      end

      // Random tables.
      for (int t = 0; t < 20; t++) begin
         logic [31:0] b;
         b = 32'(($urandom % 16) * 8);
         random_table(b, 1 + int'($urandom % 5));
         one_shot(b | 32'($urandom % 4), 1'($urandom), 1'($urandom), 1'($urandom),
                  "R1 random");
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin : watchdog
      repeat (180000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end
endmodule